// File: doc/BRIEF.md
# Time-Multiplexed Constant Multiplier

This block multiplies an unsigned data word by one constant taken from a small set that is fixed when the design is elaborated. It has no hardware multiplier. One network of shifted adders forms the product. Each adder stage takes the data word shifted by its bit position and either adds it, subtracts it or skips it. A digit table, indexed by the select input, drives the multiplexers that make this choice. The table holds a signed-digit recoding of every constant in the set, so the same adders realise every constant, one constant per cycle.

The full product has fractional constant bits at its low end. The block removes them with a logical right shift that truncates. It then loads the scaled result into an output register, together with a valid flag, one clock after the input is presented. It suits filters and transforms that reuse one datapath for several coefficients and pick the coefficient for each sample.

Top module: `tmcm_core`

## Requirements
- R1: When the index is valid, a sample accepted with `in_vld`=1 produces `out_data` = floor(`in_data` × K / 2^FRAC_W). The data is treated as unsigned, and K is the constant chosen by `in_sel`. With the defaults (16-bit data, 8-bit constants, 8 fractional bits), `out_data` is 16 bits wide.
- R2: `in_sel` is a binary index of ceil(log2(NUM_K)) bits. With the default set, index 0 selects 25, index 1 selects 27 and index 2 selects 29.
- R3: An index of NUM_K or above (3 with the defaults) gives an `out_data` of zero.
- R4: `out_vld` equals the `in_vld` of the previous cycle. `in_sel` and `in_data` are sampled on the same edge.
- R5: While `in_vld`=0, `out_data` keeps its previous value.
- R6: A synchronous active-high `rst` clears `out_data` and `out_vld` on the next edge. Reset wins over a valid sample that arrives in the same cycle.
- R7: An input of zero gives zero for every index. The maximum input of 65535 gives 6399, 6911 and 7423 for indices 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample valid |
| in_sel | input | SEL_W (2) | Constant index |
| in_data | input | DATA_W (16) | Unsigned data word |
| out_vld | output | 1 | Output valid, one cycle after `in_vld` |
| out_data | output | OUT_W (16) | Truncated scaled product |

## Verification
Reset and a valid sample can meet in the same cycle. The bench provokes this by driving `in_vld` with a nonzero word and a legal index while `rst` is high. It then checks that the next edge leaves `out_data` at zero and `out_vld` low, so reset has taken priority over the load. The random phase also places reset pulses among valid samples, held cycles and out-of-range indices. This shows that a cleared register is not later brought back to stale data.

// File: rtl/tmcm_pkg.sv
package tmcm_pkg;

  localparam int MAX_DIG = 64;

  // Signed-digit recoding: +1 digits go into the positive mask and -1 digits
  // into the negative mask. Runs of ones become one add and one subtract.
  function automatic logic [MAX_DIG-1:0] sd_mask(input int unsigned k,
                                                 input int ndig,
                                                 input bit want_neg);
    logic [MAX_DIG-1:0] m;
    longint r;
    m = '0;
    r = longint'(k);
    for (int i = 0; i < ndig; i++) begin
      if (r[0]) begin
        if (r[1]) begin
          if (want_neg) m[i] = 1'b1;
          r = r + 1;
        end else begin
          if (!want_neg) m[i] = 1'b1;
          r = r - 1;
        end
      end
      r = r >>> 1;
    end
    return m;
  endfunction

  // Number of bits needed to hold an index into a set of n entries.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tmcm_digit_tab.sv
module tmcm_digit_tab #(
  parameter int CONST_W = 8,
  parameter int NUM_K   = 3,
  parameter int NDIG    = CONST_W + 1,
  parameter int SEL_W   = 2,
  parameter logic [NUM_K*CONST_W-1:0] K_SET = {8'd29, 8'd27, 8'd25}
) (
  input  logic [SEL_W-1:0] sel,
  output logic [NDIG-1:0]  add_en,
  output logic [NDIG-1:0]  sub_en,
  output logic             sel_ok
);
  import tmcm_pkg::*;

  logic [NDIG-1:0] pos_tab [NUM_K];
  logic [NDIG-1:0] neg_tab [NUM_K];

  for (genvar j = 0; j < NUM_K; j++) begin : g_const
    localparam int unsigned KV = 32'(K_SET[j*CONST_W +: CONST_W]);
    assign pos_tab[j] = NDIG'(sd_mask(KV, NDIG, 1'b0));
    assign neg_tab[j] = NDIG'(sd_mask(KV, NDIG, 1'b1));
  end

  always_comb begin
    add_en = '0;
    sub_en = '0;
    sel_ok = 1'b0;
    for (int j = 0; j < NUM_K; j++) begin
      if (int'(sel) == j) begin
        add_en = pos_tab[j];
        sub_en = neg_tab[j];
        sel_ok = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmcm_addnet.sv
module tmcm_addnet #(
  parameter int DATA_W = 16,
  parameter int NDIG   = 9,
  parameter int PROD_W = 25
) (
  input  logic [DATA_W-1:0] x,
  input  logic [NDIG-1:0]   add_en,
  input  logic [NDIG-1:0]   sub_en,
  output logic [PROD_W-1:0] prod
);

  logic [PROD_W-1:0] x_ext;
  logic [PROD_W-1:0] acc [NDIG+1];

  assign x_ext  = PROD_W'(x);
  assign acc[0] = '0;

  // One stage per digit position. Each stage adds, subtracts or passes.
  // The partial sums wrap modulo 2^PROD_W, and the final sum is exact.
  for (genvar i = 0; i < NDIG; i++) begin : g_stage
    logic [PROD_W-1:0] term;
    assign term = x_ext << i;
    always_comb begin
      if (add_en[i])      acc[i+1] = acc[i] + term;
      else if (sub_en[i]) acc[i+1] = acc[i] - term;
      else                acc[i+1] = acc[i];
    end
  end

  assign prod = acc[NDIG];

endmodule

// File: rtl/tmcm_outreg.sv
module tmcm_outreg #(
  parameter int PROD_W = 25,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [PROD_W-1:0] prod,
  output logic              vld_q,
  output logic [OUT_W-1:0]  data_q
);

  logic [OUT_W-1:0] scaled;
  assign scaled = prod[FRAC_W +: OUT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= ld;
      if (ld) data_q <= scaled;
    end
  end

endmodule

// File: rtl/tmcm_core.sv
module tmcm_core #(
  parameter int DATA_W  = 16,
  parameter int CONST_W = 8,
  parameter int FRAC_W  = 8,
  parameter int NUM_K   = 3,
  parameter logic [NUM_K*CONST_W-1:0] K_SET = {8'd29, 8'd27, 8'd25},
  localparam int SEL_W  = tmcm_pkg::idx_bits(NUM_K),
  localparam int OUT_W  = DATA_W + CONST_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [OUT_W-1:0]  out_data
);

  localparam int NDIG   = CONST_W + 1;
  localparam int PROD_W = DATA_W + CONST_W + 1;

  logic [NDIG-1:0]   add_en;
  logic [NDIG-1:0]   sub_en;
  logic              sel_ok;
  logic [PROD_W-1:0] prod_full;

  tmcm_digit_tab #(
    .CONST_W(CONST_W), .NUM_K(NUM_K), .NDIG(NDIG),
    .SEL_W(SEL_W), .K_SET(K_SET)
  ) u_tab (
    .sel(in_sel), .add_en(add_en), .sub_en(sub_en), .sel_ok(sel_ok)
  );

  tmcm_addnet #(
    .DATA_W(DATA_W), .NDIG(NDIG), .PROD_W(PROD_W)
  ) u_net (
    .x(in_data), .add_en(add_en), .sub_en(sub_en), .prod(prod_full)
  );

  tmcm_outreg #(
    .PROD_W(PROD_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)
  ) u_reg (
    .clk(clk), .rst(rst), .ld(in_vld), .prod(prod_full),
    .vld_q(out_vld), .data_q(out_data)
  );

endmodule

// File: rtl/tmcm_core_chk.sv
module tmcm_core_chk #(
  parameter int DATA_W = 16,
  parameter int NUM_K  = 3,
  parameter int SEL_W  = 2,
  parameter int OUT_W  = 16,
  parameter int PROD_W = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [SEL_W-1:0]  in_sel,
  input logic [DATA_W-1:0] in_data,
  input logic              out_vld,
  input logic [OUT_W-1:0]  out_data,
  input logic              sel_ok,
  input logic [PROD_W-1:0] prod_full
);

  AST_PROD_FITS: assert property (@(posedge clk) disable iff (rst)
    !prod_full[PROD_W-1]); // R1
  AST_SEL_DECODE: assert property (@(posedge clk) disable iff (rst)
    (int'(in_sel) >= NUM_K) |-> !sel_ok); // R2
  AST_BAD_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_vld && int'(in_sel) >= NUM_K) |=> (out_data == '0)); // R3
  AST_VLD_RISE: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R4
  AST_VLD_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_data)); // R5
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_vld && out_data == '0)); // R6
  AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_data == '0) |=> (out_data == '0)); // R7

endmodule

bind tmcm_core tmcm_core_chk #(
  .DATA_W(DATA_W), .NUM_K(NUM_K), .SEL_W(SEL_W),
  .OUT_W(OUT_W), .PROD_W(PROD_W)
) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_sel(in_sel),
  .in_data(in_data), .out_vld(out_vld), .out_data(out_data),
  .sel_ok(sel_ok), .prod_full(prod_full)
);

// File: tb/tmcm_core_tb_top.sv
module tmcm_core_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_vld;
  logic [1:0]  in_sel;
  logic [15:0] in_data;
  logic        out_vld;
  logic [15:0] out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [15:0] exp_data;

  always #10 clk = ~clk;

  tmcm_core dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_sel(in_sel),
    .in_data(in_data), .out_vld(out_vld), .out_data(out_data)
  );

  // Expected scaled product, restated as a wide multiply and a divide.
  function automatic logic [15:0] model(input logic [1:0] s, input logic [15:0] d);
    int unsigned k;
    case (s)
      2'd0: k = 25;
      2'd1: k = 27;
      2'd2: k = 29;
      default: k = 0;
    endcase
    return 16'((int'(d) * k) / 256);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", tag, got, want);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, then sample.
  task automatic step(input logic r, input logic v, input logic [1:0] s,
                      input logic [15:0] d, input string tag);
    @(negedge clk);
    rst = r; in_vld = v; in_sel = s; in_data = d;
    @(posedge clk);
    #2;
    if (r) exp_data = '0;
    else if (v) exp_data = model(s, d);
    check({tag, " data"}, 32'(out_data), 32'(exp_data));
    check({tag, " vld"}, 32'(out_vld), 32'(v & ~r));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    rst = 1'b1; in_vld = 1'b0; in_sel = '0; in_data = '0;
    exp_data = '0;
    step(1'b1, 1'b0, 2'd0, 16'd0, "R6 reset");
    // Reset and a valid load in the same cycle: reset must win.
    step(1'b1, 1'b1, 2'd2, 16'd40000, "R6 reset beats load");

    step(1'b0, 1'b1, 2'd0, 16'd256, "R2 index0 is 25");
    step(1'b0, 1'b1, 2'd1, 16'd256, "R2 index1 is 27");
    step(1'b0, 1'b1, 2'd2, 16'd256, "R2 index2 is 29");
    for (int s = 0; s < 3; s++) begin
      step(1'b0, 1'b1, 2'(s), 16'd0, "R7 zero input");
      step(1'b0, 1'b1, 2'(s), 16'hFFFF, "R7 max input");
    end
    check("R7 max idx2 literal", 32'(out_data), 32'd7423);
    step(1'b0, 1'b1, 2'd0, 16'd1, "R1 truncation of tiny input");
    step(1'b0, 1'b1, 2'd3, 16'hFFFF, "R3 bad index");
    step(1'b0, 1'b1, 2'd1, 16'd1234, "R1 load");
    step(1'b0, 1'b0, 2'd2, 16'd999, "R5 hold");
    step(1'b0, 1'b0, 2'd3, 16'd7, "R5 hold again");
    step(1'b0, 1'b1, 2'd2, 16'd777, "R4 valid after gap");

    for (int n = 0; n < 400; n++) begin
      logic r, v;
      logic [1:0] s;
      logic [15:0] d;
      r = ($urandom % 23) == 0;
      v = ($urandom % 4) != 0;
      s = 2'($urandom % 4);
      d = 16'($urandom);
      step(r, v, s, d, r ? "R6 random reset" : (v ? "R1 random" : "R5 random hold"));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule